// File: doc/BRIEF.md
# Memory Cycle Sequencer

This block sits between a processor's control logic and an asynchronous memory bus. The processor asks it for a read, a write or a read-modify-write. The block raises the read and write lines and the cycle request, then waits for the memory's address acknowledge and, on reads, for the read restart. On writes it places its data buffer on the bus and strobes the write restart itself. When a cycle finishes, two restart steps follow and the second one signals completion. A held stop flag blocks these steps.

Relocation is worked out elsewhere: the block only receives an address-legal bit and a relocation-inhibit bit. An address that fails both is refused at once and the error exit is taken. A programmable cycle count catches memory that never answers. When it runs out, the block sets a flag and, unless memory-disable is on, fakes the answers the memory would have given.

The write half of a read-modify-write can reuse the open cycle, or it can go out as a fresh write request when split cycles are selected. A stop flag, set by the memory-stop key or by an address match with the address-stop switch on, holds the controller after the memory side completes.

Top module: `mem_cycle_ctl`

## Requirements
- R1: A read command sets bus_rd_rq to 1, clears bus_wr_rq and clears data_buf, all at the command edge.
- R2: A write command clears bus_rd_rq, sets bus_wr_rq and loads cmd_wdata into data_buf.
- R3: A read-modify-write command sets both bus_rd_rq and bus_wr_rq, clears data_buf and sets stop_sync.
- R4: At any request, bus_cyc_rq rises only if addr_ok or rel_inhibit is 1. Otherwise illeg_addr is set, err_exit pulses for one cycle and the controller returns to idle.
- R5: Each request recomputes `stopped` as key_mem_stop OR (sw_addr_stop AND request address == addr_sw). key_resume pulses for one cycle when `stopped` becomes 1 while key_mem_cont is 1.
- R6: An address acknowledge clears bus_cyc_rq at that edge. If only the write line is set, bus_wr_rs is high for exactly the next cycle, with bus_wdata equal to data_buf.
- R7: A read restart loads bus_rdata into data_buf. If bus_addr equals addr_sw, it also loads bus_rdata into mem_ind.
- R8: A write restart issued by the block copies the written data into mem_ind when bus_addr equals addr_sw.
- R9: If `stopped` is 0, the edge that completes a restart is followed by one step cycle and then one cycle with done high, after which bus_rd_rq is 0. If `stopped` is 1, done never rises for that cycle.
- R10: The request is raised at edge E0. If no acknowledge arrives by edge E0+timeout_lim+1 and `stopped` is 0, non_exist is set at that edge. An acknowledge at that same edge takes precedence, and non_exist stays 0.
- R11: On timeout with sw_mem_disable at 0, the block fakes the acknowledge. A write then strobes bus_wr_rs; a read goes straight to the restart steps with data_buf left at 0. With sw_mem_disable at 1, bus_cyc_rq stays high and the block waits for a real acknowledge.
- R12: The write phase of a read-modify-write (cmd_rmw_wr) loads cmd_wdata into data_buf and clears stop_sync. With cmd_split at 1 it issues a new write request under R4, using the held address. With cmd_split at 0 it strobes bus_wr_rs in the next cycle without a new request.
- R13: Every new request clears illeg_addr and non_exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rd | input | 1 | Read command pulse |
| cmd_wr | input | 1 | Write command pulse |
| cmd_rmw | input | 1 | Read-modify-write command pulse |
| cmd_rmw_wr | input | 1 | Write phase of a read-modify-write |
| cmd_split | input | 1 | Split-cycle select for the write phase |
| cmd_wdata | input | DW | Write data |
| cmd_addr | input | AW | Request address |
| addr_ok | input | 1 | Relocated address is within bounds |
| rel_inhibit | input | 1 | Relocation is inhibited |
| addr_sw | input | AW | Address switches |
| key_mem_stop | input | 1 | Memory-stop key |
| key_mem_cont | input | 1 | Memory-continue key |
| sw_addr_stop | input | 1 | Address-stop switch |
| sw_mem_disable | input | 1 | Suppress faked answers on timeout |
| timeout_lim | input | TW | Timeout count limit |
| bus_rd_rq | output | 1 | Read request line |
| bus_wr_rq | output | 1 | Write request line |
| bus_cyc_rq | output | 1 | Cycle request line |
| bus_addr | output | AW | Address on the bus |
| bus_addr_ack | input | 1 | Address acknowledge from memory |
| bus_rd_rs | input | 1 | Read restart from memory |
| bus_rdata | input | DW | Read data |
| bus_wdata | output | DW | Write data on the bus |
| bus_wr_rs | output | 1 | Write restart strobe |
| data_buf | output | DW | Data buffer register |
| mem_ind | output | DW | Memory indicator register |
| stopped | output | 1 | Stop flag |
| stop_sync | output | 1 | Read-modify-write in progress |
| illeg_addr | output | 1 | Illegal address flag |
| non_exist | output | 1 | Non-existent memory flag |
| err_exit | output | 1 | Error exit pulse |
| key_resume | output | 1 | Resume-at-key-sequence pulse |
| done | output | 1 | Completion (restart step 1) |

## Verification
A real address acknowledge and the expiry of the timeout can land on the same edge. In that case the real acknowledge must win and non_exist must not be set. The bench provokes this with a small limit and raises the acknowledge exactly at edge E0+timeout_lim+1. It then checks that non_exist stays 0, that the write restart still fires once, and that done follows. The bench also confirms the other side of the boundary: with no acknowledge, the same edge sets the flag and the faked acknowledge takes effect.

// File: rtl/mem_cycle_ctl.sv
module mem_cycle_ctl #(
  parameter int DW = 36,
  parameter int AW = 18,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_rd,
  input  logic          cmd_wr,
  input  logic          cmd_rmw,
  input  logic          cmd_rmw_wr,
  input  logic          cmd_split,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [AW-1:0] cmd_addr,
  input  logic          addr_ok,
  input  logic          rel_inhibit,
  input  logic [AW-1:0] addr_sw,
  input  logic          key_mem_stop,
  input  logic          key_mem_cont,
  input  logic          sw_addr_stop,
  input  logic          sw_mem_disable,
  input  logic [TW-1:0] timeout_lim,
  output logic          bus_rd_rq,
  output logic          bus_wr_rq,
  output logic          bus_cyc_rq,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_addr_ack,
  input  logic          bus_rd_rs,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wr_rs,
  output logic [DW-1:0] data_buf,
  output logic [DW-1:0] mem_ind,
  output logic          stopped,
  output logic          stop_sync,
  output logic          illeg_addr,
  output logic          non_exist,
  output logic          err_exit,
  output logic          key_resume,
  output logic          done
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT_ACK, S_WAIT_RS, S_T0, S_T1} st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic [AW-1:0] ma;

  logic          idle, fresh, new_rq, direct_wr, legal, stop_now, match;
  logic          ack, tmo, fake, ack_any, wr_only, issue_wr;
  logic [AW-1:0] rq_addr;

  assign idle      = (st == S_IDLE);
  assign fresh     = cmd_rd | cmd_wr | cmd_rmw;
  assign new_rq    = idle & (fresh | (cmd_rmw_wr & cmd_split));
  assign direct_wr = idle & !fresh & cmd_rmw_wr & !cmd_split;
  assign rq_addr   = fresh ? cmd_addr : ma;
  assign legal     = addr_ok | rel_inhibit;
  assign stop_now  = key_mem_stop | (sw_addr_stop & (rq_addr == addr_sw));
  assign match     = (ma == addr_sw);
  assign ack       = (st == S_WAIT_ACK) & bus_addr_ack;
  assign tmo       = (st == S_WAIT_ACK) & !bus_addr_ack & !stopped & !non_exist & (cnt == timeout_lim);
  assign fake      = tmo & !sw_mem_disable;
  assign ack_any   = ack | fake;
  assign wr_only   = bus_wr_rq & !bus_rd_rq;
  assign issue_wr  = (ack_any & wr_only) | direct_wr;

  assign bus_addr  = ma;
  assign bus_wdata = data_buf;
  assign done      = (st == S_T1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      ma         <= '0;
      bus_rd_rq  <= 1'b0;
      bus_wr_rq  <= 1'b0;
      bus_cyc_rq <= 1'b0;
      bus_wr_rs  <= 1'b0;
      data_buf   <= '0;
      mem_ind    <= '0;
      stopped    <= 1'b0;
      stop_sync  <= 1'b0;
      illeg_addr <= 1'b0;
      non_exist  <= 1'b0;
      err_exit   <= 1'b0;
      key_resume <= 1'b0;
    end else begin
      bus_wr_rs  <= issue_wr;
      err_exit   <= 1'b0;
      key_resume <= 1'b0;
      case (st)
        S_IDLE: begin
          if (new_rq) begin
            if (cmd_rd) begin
              bus_rd_rq <= 1'b1; bus_wr_rq <= 1'b0; data_buf <= '0;
            end else if (cmd_wr) begin
              bus_rd_rq <= 1'b0; bus_wr_rq <= 1'b1; data_buf <= cmd_wdata;
            end else if (cmd_rmw) begin
              bus_rd_rq <= 1'b1; bus_wr_rq <= 1'b1; data_buf <= '0; stop_sync <= 1'b1;
            end else begin
              bus_rd_rq <= 1'b0; bus_wr_rq <= 1'b1; data_buf <= cmd_wdata; stop_sync <= 1'b0;
            end
            if (fresh) ma <= cmd_addr;
            stopped    <= stop_now;
            key_resume <= stop_now & key_mem_cont;
            illeg_addr <= !legal;
            non_exist  <= 1'b0;
            cnt        <= '0;
            if (legal) begin
              bus_cyc_rq <= 1'b1;
              st         <= S_WAIT_ACK;
            end else begin
              err_exit   <= 1'b1;
            end
          end else if (direct_wr) begin
            data_buf  <= cmd_wdata;
            stop_sync <= 1'b0;
            if (match) mem_ind <= cmd_wdata;
            st <= stopped ? S_IDLE : S_T0;
          end
        end
        S_WAIT_ACK: begin
          cnt <= cnt + TW'(1);
          if (tmo) non_exist <= 1'b1;
          if (ack_any) begin
            bus_cyc_rq <= 1'b0;
            if (wr_only) begin
              if (match) mem_ind <= data_buf;
              st <= stopped ? S_IDLE : S_T0;
            end else if (bus_rd_rq) begin
              st <= fake ? S_T0 : S_WAIT_RS;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_WAIT_RS: begin
          if (bus_rd_rs) begin
            data_buf <= bus_rdata;
            if (match) mem_ind <= bus_rdata;
            st <= stopped ? S_IDLE : S_T0;
          end
        end
        S_T0: st <= S_T1;
        S_T1: begin
          bus_rd_rq <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RQ_ONLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cyc_rq) |-> !illeg_addr); // R4
  AST_ERR_NO_RQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_exit |-> (illeg_addr && !bus_cyc_rq)); // R4
  AST_ACK_DROPS_RQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_ACK && bus_addr_ack) |=> !bus_cyc_rq); // R6
  AST_WRS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_rs |=> !bus_wr_rs); // R6
  AST_WRS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_rs |-> (bus_wr_rq && !bus_cyc_rq)); // R6
  AST_WRS_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_rs && !stopped) |=> done); // R9
  AST_DONE_CLEARS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bus_rd_rq); // R9
  AST_NXM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(non_exist) |-> $past(bus_cyc_rq && !stopped && !bus_addr_ack)); // R10

endmodule

// File: tb/mem_cycle_ctl_test.sv
module mem_cycle_ctl_test;
  localparam int DW = 36;
  localparam int AW = 18;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_rd = 0, cmd_wr = 0, cmd_rmw = 0, cmd_rmw_wr = 0, cmd_split = 0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic addr_ok = 1, rel_inhibit = 0;
  logic [AW-1:0] addr_sw = 18'h00A5;
  logic key_mem_stop = 0, key_mem_cont = 0, sw_addr_stop = 0, sw_mem_disable = 0;
  logic [TW-1:0] timeout_lim = 16'd200;
  logic bus_addr_ack = 0, bus_rd_rs = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic bus_rd_rq, bus_wr_rq, bus_cyc_rq, bus_wr_rs;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, data_buf, mem_ind;
  logic stopped, stop_sync, illeg_addr, non_exist, err_exit, key_resume, done;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_mi = '0;

  always #10 clk = ~clk;

  mem_cycle_ctl #(.DW(DW), .AW(AW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_rmw(cmd_rmw),
    .cmd_rmw_wr(cmd_rmw_wr), .cmd_split(cmd_split), .cmd_wdata(cmd_wdata), .cmd_addr(cmd_addr),
    .addr_ok(addr_ok), .rel_inhibit(rel_inhibit), .addr_sw(addr_sw),
    .key_mem_stop(key_mem_stop), .key_mem_cont(key_mem_cont), .sw_addr_stop(sw_addr_stop),
    .sw_mem_disable(sw_mem_disable), .timeout_lim(timeout_lim),
    .bus_rd_rq(bus_rd_rq), .bus_wr_rq(bus_wr_rq), .bus_cyc_rq(bus_cyc_rq), .bus_addr(bus_addr),
    .bus_addr_ack(bus_addr_ack), .bus_rd_rs(bus_rd_rs), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_wr_rs(bus_wr_rs), .data_buf(data_buf), .mem_ind(mem_ind),
    .stopped(stopped), .stop_sync(stop_sync), .illeg_addr(illeg_addr), .non_exist(non_exist),
    .err_exit(err_exit), .key_resume(key_resume), .done(done));

  typedef struct packed {
    logic          is_wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 18'h00A5, 36'h123456789},
    '{1'b1, 18'h00A5, 36'hFEDCBA987},
    '{1'b0, 18'h0100, 36'h0F0F0F0F0},
    '{1'b1, 18'h3FFFF, 36'hAAAAAAAAA},
    '{1'b0, 18'h00A4, 36'h555555555},
    '{1'b1, 18'h00A5, 36'h000000001}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [DW-1:0] d);
    cmd_rd = 1; cmd_addr = a; tick(); cmd_rd = 0;
    check("R1 rd line", {bus_rd_rq, bus_wr_rq, bus_cyc_rq}, 3'b101);
    check("R1 buffer cleared", data_buf, 0);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    check("R6 rq dropped on ack", bus_cyc_rq, 0);
    bus_rd_rs = 1; bus_rdata = d; tick(); bus_rd_rs = 0;
    if (a == addr_sw) exp_mi = d;
    check("R7 read data latched", data_buf, d);
    check("R7 indicator", mem_ind, exp_mi);
    check("R9 step0 not done", done, 0);
    tick();
    check("R9 done in step1", done, 1);
    tick();
    check("R9 rd line cleared", {done, bus_rd_rq}, 2'b00);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    cmd_wr = 1; cmd_addr = a; cmd_wdata = d; tick(); cmd_wr = 0;
    check("R2 wr lines", {bus_rd_rq, bus_wr_rq, bus_cyc_rq}, 3'b011);
    check("R2 buffer loaded", data_buf, d);
    check("R6 no strobe before ack", bus_wr_rs, 0);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    if (a == addr_sw) exp_mi = d;
    check("R6 write strobe", {bus_wr_rs, bus_cyc_rq}, 2'b10);
    check("R6 write data on bus", bus_wdata, d);
    check("R8 indicator", mem_ind, exp_mi);
    tick();
    check("R9 done after write", {done, bus_wr_rs}, 2'b10);
    tick();
    check("R9 done single", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R4 reset lines", {bus_rd_rq, bus_wr_rq, bus_cyc_rq, bus_wr_rs, done}, 0);
    check("R13 reset flags", {illeg_addr, non_exist, stopped, stop_sync}, 0);
    rst_n = 1; tick();

    for (int i = 0; i < 6; i++) begin
      if (VECS[i].is_wr) do_write(VECS[i].addr, VECS[i].data);
      else do_read(VECS[i].addr, VECS[i].data);
    end

    // R4 illegal address
    addr_ok = 0; cmd_rd = 1; cmd_addr = 18'h200; tick(); cmd_rd = 0;
    check("R4 illegal flagged", {illeg_addr, err_exit, bus_cyc_rq}, 3'b110);
    tick();
    check("R4 err_exit one cycle", {err_exit, bus_cyc_rq}, 2'b00);
    // R13 inhibited relocation makes it legal and clears the flag
    rel_inhibit = 1; cmd_rd = 1; tick(); cmd_rd = 0;
    check("R4 inhibit allows request", {illeg_addr, bus_cyc_rq}, 2'b01);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    bus_rd_rs = 1; bus_rdata = 36'h77; tick(); bus_rd_rs = 0;
    tick(); tick();
    addr_ok = 1; rel_inhibit = 0;

    // R5 memory-stop key with continue
    key_mem_stop = 1; key_mem_cont = 1;
    cmd_wr = 1; cmd_addr = 18'h11; cmd_wdata = 36'h99; tick(); cmd_wr = 0;
    key_mem_stop = 0; key_mem_cont = 0;
    check("R5 stop and resume", {stopped, key_resume}, 2'b11);
    tick();
    check("R5 resume pulse ends", key_resume, 0);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    check("R6 strobe while stopped", bus_wr_rs, 1);
    tick();
    check("R9 no done when stopped", done, 0);
    tick();
    check("R9 still no done", done, 0);

    // R5 address-stop match; R10 no timeout while stopped
    sw_addr_stop = 1; timeout_lim = 16'd3;
    cmd_rd = 1; cmd_addr = addr_sw; tick(); cmd_rd = 0;
    check("R5 address stop", {stopped, key_resume}, 2'b10);
    repeat (10) tick();
    check("R10 no timeout when stopped", {non_exist, bus_cyc_rq}, 2'b01);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    bus_rd_rs = 1; bus_rdata = 36'h5A5; tick(); bus_rd_rs = 0;
    exp_mi = 36'h5A5;
    check("R7 indicator on match", mem_ind, exp_mi);
    tick();
    check("R9 stopped read no done", done, 0);
    sw_addr_stop = 0;
    // non-matching address clears the stop flag
    do_read(18'h33, 36'h44);
    check("R5 stop cleared", stopped, 0);

    // R10 R11 write timeout fakes acknowledge
    timeout_lim = 16'd4;
    cmd_wr = 1; cmd_addr = 18'h40; cmd_wdata = 36'hBEE; tick(); cmd_wr = 0;
    repeat (4) tick();
    check("R10 not yet timed out", {non_exist, bus_cyc_rq}, 2'b01);
    tick();
    check("R10 timeout flag", non_exist, 1);
    check("R11 faked write strobe", {bus_wr_rs, bus_cyc_rq}, 2'b10);
    tick();
    check("R11 done after fake", done, 1);
    tick();

    // R11 read timeout
    cmd_rd = 1; cmd_addr = 18'h41; tick(); cmd_rd = 0;
    check("R13 flag cleared by request", non_exist, 0);
    repeat (5) tick();
    check("R11 faked read restart", {non_exist, bus_cyc_rq, done}, 3'b100);
    tick();
    check("R11 read done buffer zero", {done, 36'(data_buf)}, {1'b1, 36'h0});
    tick();

    // R11 memory disable waits for real ack
    sw_mem_disable = 1;
    cmd_rd = 1; cmd_addr = 18'h42; tick(); cmd_rd = 0;
    repeat (8) tick();
    check("R11 disabled keeps request", {non_exist, bus_cyc_rq, done}, 3'b110);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    bus_rd_rs = 1; bus_rdata = 36'hCAFE; tick(); bus_rd_rs = 0;
    check("R11 late real data", data_buf, 36'hCAFE);
    tick();
    check("R11 late done", done, 1);
    tick();
    sw_mem_disable = 0;

    // R10 acknowledge on the timeout edge wins
    cmd_wr = 1; cmd_addr = 18'h43; cmd_wdata = 36'h321; tick(); cmd_wr = 0;
    repeat (4) tick();
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    check("R10 ack beats timeout", {non_exist, bus_wr_rs}, 2'b01);
    tick();
    check("R10 done once", done, 1);
    tick();
    check("R6 single strobe", bus_wr_rs, 0);
    timeout_lim = 16'd200;

    // R3 R12 read-modify-write, in place
    cmd_rmw = 1; cmd_addr = addr_sw; tick(); cmd_rmw = 0;
    check("R3 both lines", {bus_rd_rq, bus_wr_rq, bus_cyc_rq, stop_sync}, 4'b1111);
    check("R3 buffer cleared", data_buf, 0);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    check("R3 no write strobe on rmw ack", bus_wr_rs, 0);
    bus_rd_rs = 1; bus_rdata = 36'h111; tick(); bus_rd_rs = 0;
    tick(); tick();
    check("R9 rmw read lines", {bus_rd_rq, bus_wr_rq}, 2'b01);
    cmd_rmw_wr = 1; cmd_split = 0; cmd_wdata = 36'h222; tick(); cmd_rmw_wr = 0;
    check("R12 direct strobe", {bus_wr_rs, bus_cyc_rq, stop_sync}, 3'b100);
    check("R12 direct data", bus_wdata, 36'h222);
    check("R8 rmw indicator", mem_ind, 36'h222);
    tick();
    check("R12 direct done", done, 1);
    tick();

    // R12 split write phase
    cmd_rmw = 1; cmd_addr = 18'h60; tick(); cmd_rmw = 0;
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    bus_rd_rs = 1; bus_rdata = 36'h333; tick(); bus_rd_rs = 0;
    tick(); tick();
    cmd_rmw_wr = 1; cmd_split = 1; cmd_wdata = 36'h444; tick(); cmd_rmw_wr = 0; cmd_split = 0;
    check("R12 split new request", {bus_rd_rq, bus_wr_rq, bus_cyc_rq, bus_wr_rs}, 4'b0110);
    check("R12 split held address", bus_addr, 18'h60);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    check("R12 split strobe", {bus_wr_rs, 36'(bus_wdata)}, {1'b1, 36'h444});
    tick();
    check("R12 split done", done, 1);
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule